// File: doc/BRIEF.md
# Security-Banked System Control Register

This block is one configuration register inside a system control coprocessor. It keeps two copies of the low control bits: one for the secure world and one for the non-secure world. The copies hold MMU enable, strict alignment checking and level-one data cache enable. The block also keeps one copy each of two bits that only the secure world may change: high exception vectors and unaligned-access enable.

A coprocessor access is presented for one cycle. It carries opcode and register-number fields, a read/write flag, the processor's privilege level and its security state. The block decodes the address and applies the access rules. One cycle later it returns the read data and a one-cycle undefined-instruction flag. The active control outputs are taken from the copy that belongs to the current security state.

Top module: `sys_ctrl_bank`

## Requirements
- R1: After reset, both copies of MMU enable (bit 0), alignment check (bit 1) and data cache enable (bit 2) are 0. High vectors (bit 13) equals `strap_hivec_i`. Unaligned enable (bit 22) is 0.
- R2: An access is for this register only when opcode1=0, CRn=1, CRm=0 and opcode2=0. Any other access leaves the state unchanged. It returns a zero read value and does not raise the undefined flag.
- R3: A read or write from user mode (`priv_i`=0), in either world, raises `acc_undef_o` in the next cycle, returns zero read data and changes nothing.
- R4: A secure privileged write while `wr_lock_i` is high raises `acc_undef_o` and is discarded. With the lock low, the same write is accepted. The lock does not affect reads.
- R5: Bits 0 to 2 are banked. Secure accesses read and write the secure copy, and non-secure accesses read and write the non-secure copy.
- R6: A non-secure privileged write leaves bits 13 and 22 unchanged and raises no undefined flag. Its bits 0 to 2 are still written.
- R7: A read of bits 13 and 22 from either world returns the single secure value.
- R8: The active MMU, alignment and cache outputs come from the secure copy when `secure_i`=1 and from the non-secure copy otherwise. They take a written value from the clock edge that accepts the write.
- R9: `align_chk_o` follows the active alignment bit. `unalign_en_o` is the unaligned enable bit gated off whenever the active alignment bit is 1.
- R10: Read data returned by an accepted read is registered and appears one cycle after the access. All bits other than 0, 1, 2, 13 and 22 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_hivec_i | input | 1 | Reset value of the high-vectors bit |
| secure_i | input | 1 | Core is in the secure state |
| priv_i | input | 1 | Core is in a privileged mode |
| wr_lock_i | input | 1 | Blocks secure privileged writes |
| acc_valid_i | input | 1 | Coprocessor access strobe, one cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_op1_i | input | 3 | Opcode1 field |
| acc_crn_i | input | 4 | Primary register number |
| acc_crm_i | input | 4 | Secondary register number |
| acc_op2_i | input | 3 | Opcode2 field |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, one cycle after the access |
| acc_undef_o | output | 1 | Undefined-instruction flag, one cycle after the access |
| mmu_en_o | output | 1 | Active MMU enable |
| align_chk_o | output | 1 | Active strict alignment checking |
| dcache_en_o | output | 1 | Active data cache enable |
| hivec_o | output | 1 | High exception vectors |
| unalign_en_o | output | 1 | Unaligned access enable after alignment priority |

## Verification
The hardest situation to reach is the one where the two banked copies hold different values while the secure-only bits have been moved away from their reset values. Only then do the banking, read-through and ignore rules give distinguishable results. The stimulus first writes different patterns from each world. It then tries to overwrite the secure-only bits from the non-secure world with all ones, and applies the write lock between two secure writes. Reads from both worlds and the outputs in both values of `secure_i` are compared at each step.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W = 32;
  localparam int NBANK  = 3;
  localparam int BIT_M  = 0;
  localparam int BIT_A  = 1;
  localparam int BIT_C  = 2;
  localparam int BIT_V  = 13;
  localparam int BIT_U  = 22;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_UNDEF,
    ACC_WR_SEC,
    ACC_WR_NSEC
  } acc_kind_e;

  function automatic logic [DATA_W-1:0] pack_word(logic [NBANK-1:0] bank, logic v, logic u);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_M] = bank[BIT_M];
    w[BIT_A] = bank[BIT_A];
    w[BIT_C] = bank[BIT_C];
    w[BIT_V] = v;
    w[BIT_U] = u;
    return w;
  endfunction
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       priv_i,
  input  logic       secure_i,
  input  logic       lock_i,
  output logic       sel_o,
  output acc_kind_e  kind_o
);
  assign sel_o = valid_i && op1_i == 3'd0 && crn_i == 4'd1 && crm_i == 4'd0 && op2_i == 3'd0;

  always_comb begin
    kind_o = ACC_IDLE;
    if (sel_o) begin
      if (!priv_i)                 kind_o = ACC_UNDEF;
      else if (!write_i)           kind_o = ACC_READ;
      else if (secure_i && lock_i) kind_o = ACC_UNDEF;
      else if (secure_i)           kind_o = ACC_WR_SEC;
      else                         kind_o = ACC_WR_NSEC;
    end
  end
endmodule

// File: rtl/scr_bank.sv
module scr_bank #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
  import scr_pkg::*;
#(
  parameter logic U_RESET = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_hivec_i,
  input  logic              secure_i,
  input  logic              priv_i,
  input  logic              wr_lock_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [2:0]        acc_op1_i,
  input  logic [3:0]        acc_crn_i,
  input  logic [3:0]        acc_crm_i,
  input  logic [2:0]        acc_op2_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              acc_undef_o,
  output logic              mmu_en_o,
  output logic              align_chk_o,
  output logic              dcache_en_o,
  output logic              hivec_o,
  output logic              unalign_en_o
);
  logic            sel;
  acc_kind_e       kind;
  logic [NBANK-1:0] bank_q [2];  // [0] non-secure, [1] secure
  logic [NBANK-1:0] act;
  logic            v_q, u_q;
  logic            unused_wdata;

  assign unused_wdata = ^{acc_wdata_i[DATA_W-1:BIT_U+1], acc_wdata_i[BIT_U-1:BIT_V+1],
                          acc_wdata_i[BIT_V-1:NBANK]};

  scr_decode u_dec (
    .valid_i (acc_valid_i), .write_i (acc_write_i),
    .op1_i   (acc_op1_i),   .crn_i   (acc_crn_i),
    .crm_i   (acc_crm_i),   .op2_i   (acc_op2_i),
    .priv_i  (priv_i),      .secure_i(secure_i),
    .lock_i  (wr_lock_i),   .sel_o   (sel),
    .kind_o  (kind)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_world
    scr_bank #(.W(NBANK), .RST_VAL('0)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (kind == (gi == 1 ? ACC_WR_SEC : ACC_WR_NSEC)),
      .wdata_i(acc_wdata_i[NBANK-1:0]),
      .q_o    (bank_q[gi])
    );
  end

  // secure-only single-copy bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= strap_hivec_i;
      u_q <= U_RESET;
    end else if (kind == ACC_WR_SEC) begin
      v_q <= acc_wdata_i[BIT_V];
      u_q <= acc_wdata_i[BIT_U];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_rdata_o <= '0;
      acc_undef_o <= 1'b0;
    end else begin
      acc_undef_o <= (kind == ACC_UNDEF);
      acc_rdata_o <= (kind == ACC_READ) ? pack_word(bank_q[secure_i ? 1 : 0], v_q, u_q) : '0;
    end
  end

  assign act          = bank_q[secure_i ? 1 : 0];
  assign mmu_en_o     = act[BIT_M];
  assign align_chk_o  = act[BIT_A];
  assign dcache_en_o  = act[BIT_C];
  assign hivec_o      = v_q;
  assign unalign_en_o = u_q && !act[BIT_A];

  p_nosel_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !sel) |=> (!acc_undef_o && acc_rdata_o == '0));
  p_user_undef_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !priv_i) |=> (acc_undef_o && acc_rdata_o == '0));
  p_user_nochg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !priv_i) |=> ($stable(bank_q[0]) && $stable(bank_q[1]) && $stable(v_q) && $stable(u_q)));
  p_lock_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && priv_i && secure_i && acc_write_i && wr_lock_i) |=>
    (acc_undef_o && $stable(bank_q[1]) && $stable(v_q) && $stable(u_q)));
  p_ns_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && priv_i && !secure_i && acc_write_i) |=>
    (!acc_undef_o && $stable(v_q) && $stable(u_q) && $stable(bank_q[1])));
  p_align_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_chk_o |-> !unalign_en_o);
endmodule

// File: tb/sys_ctrl_bank_test.sv
module sys_ctrl_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        strap = 1;
  logic        sec = 1, priv = 1, lock = 0;
  logic        valid = 0, wr = 0;
  logic [2:0]  op1 = 0, op2 = 0;
  logic [3:0]  crn = 1, crm = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        undef, mmu, align, dcache, hivec, unalign;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] r_data;
  logic        r_undef;

  always #5 clk = ~clk;

  sys_ctrl_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_hivec_i(strap), .secure_i(sec), .priv_i(priv),
    .wr_lock_i(lock), .acc_valid_i(valid), .acc_write_i(wr), .acc_op1_i(op1),
    .acc_crn_i(crn), .acc_crm_i(crm), .acc_op2_i(op2), .acc_wdata_i(wdata),
    .acc_rdata_o(rdata), .acc_undef_o(undef), .mmu_en_o(mmu), .align_chk_o(align),
    .dcache_en_o(dcache), .hivec_o(hivec), .unalign_en_o(unalign)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle access; result sampled one cycle later
  task automatic acc(logic s, logic p, logic w, logic [31:0] d, logic good_addr = 1);
    @(negedge clk);
    sec = s; priv = p; wr = w; wdata = d; valid = 1;
    crn = good_addr ? 4'd1 : 4'd2;
    @(negedge clk);
    valid = 0; crn = 1;
    r_data = rdata; r_undef = undef;
  endtask

  task automatic t_reset();
    sec = 1;
    @(negedge clk);
    chk("R1 outs sec", {27'd0, mmu, align, dcache, hivec, unalign}, 32'b00010);
    sec = 0; #1;
    chk("R1 outs nsec", {29'd0, mmu, align, dcache}, 0);
    acc(1, 1, 0, 0);
    chk("R1 sec read", r_data, 32'h0000_2000);
    acc(0, 1, 0, 0);
    chk("R1 nsec read", r_data, 32'h0000_2000);
  endtask

  task automatic t_decode();
    acc(1, 1, 1, 32'h7, 0);
    chk("R2 undef", {31'd0, r_undef}, 0);
    chk("R2 rdata", r_data, 0);
    acc(1, 1, 0, 0, 0);
    chk("R2 read other", r_data, 0);
    acc(1, 1, 0, 0);
    chk("R2 no change", r_data, 32'h0000_2000);
  endtask

  task automatic t_bank();
    acc(1, 1, 1, 32'h0000_2005);
    chk("R5 sec wr undef", {31'd0, r_undef}, 0);
    chk("R8 sec outs", {29'd0, mmu, align, dcache}, 32'b101);
    acc(0, 1, 1, 32'h0000_0002);
    chk("R6 ns wr no undef", {31'd0, r_undef}, 0);
    chk("R8 ns outs", {29'd0, mmu, align, dcache}, 32'b010);
    acc(0, 1, 0, 0);
    chk("R7 ns read V", r_data, 32'h0000_2002);
    acc(1, 1, 0, 0);
    chk("R5 sec copy kept", r_data, 32'h0000_2005);
  endtask

  task automatic t_ns_only();
    acc(0, 1, 1, 32'hFFFF_FFFF);
    chk("R6 undef", {31'd0, r_undef}, 0);
    acc(0, 1, 0, 0);
    chk("R6 R10 ns read", r_data, 32'h0000_2007);
    chk("R6 hivec", {31'd0, hivec}, 1);
    acc(1, 1, 0, 0);
    chk("R6 sec read", r_data, 32'h0000_2005);
  endtask

  task automatic t_user();
    acc(1, 0, 0, 0);
    chk("R3 user read undef", {31'd0, r_undef}, 1);
    chk("R3 user read data", r_data, 0);
    acc(1, 0, 1, 0);
    chk("R3 user write undef", {31'd0, r_undef}, 1);
    acc(0, 0, 1, 0);
    chk("R3 ns user write undef", {31'd0, r_undef}, 1);
    acc(1, 1, 0, 0);
    chk("R3 sec unchanged", r_data, 32'h0000_2005);
    acc(0, 1, 0, 0);
    chk("R3 ns unchanged", r_data, 32'h0000_2007);
  endtask

  task automatic t_lock();
    lock = 1;
    acc(1, 1, 1, 0);
    chk("R4 locked undef", {31'd0, r_undef}, 1);
    acc(1, 1, 0, 0);
    chk("R4 read under lock undef", {31'd0, r_undef}, 0);
    chk("R4 discarded", r_data, 32'h0000_2005);
    lock = 0;
    acc(1, 1, 1, 32'h0040_0002);
    chk("R4 unlocked undef", {31'd0, r_undef}, 0);
    acc(1, 1, 0, 0);
    chk("R4 accepted", r_data, 32'h0040_0002);
    chk("R4 hivec", {31'd0, hivec}, 0);
  endtask

  task automatic t_prio();
    sec = 1; #1;
    chk("R9 A wins", {30'd0, align, unalign}, 32'b10);
    acc(1, 1, 1, 32'h0040_0000);
    chk("R9 U active", {30'd0, align, unalign}, 32'b01);
    sec = 0; #1;
    chk("R9 R8 ns A wins", {30'd0, align, unalign}, 32'b10);
    acc(0, 1, 0, 0);
    chk("R7 ns sees U", r_data, 32'h0040_0007);
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_bank();
    t_ns_only();
    t_user();
    t_lock();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule